// File: doc/BRIEF.md
# Aliased System Address Decoder

This block turns a 32-bit system-bus address into a one-hot target select and a target-relative offset. The address space is split into 256 MB windows. A code window, an SRAM window holding a power-of-two number of equal banks, and a peripheral window of 4 KB slots are decoded directly. Three odd-numbered windows reflect the window just below them. A handful of secure-only register blocks occupy the upper reflected window and take precedence over its reflection. Any address that neither a direct region nor a reflection can resolve raises a decode-error flag.

The result is registered, so it appears one clock after the address is presented. Bus handshakes, access permission checks and the targets themselves lie outside the block. The bank count `NBANK` must be a power of two no larger than 16. The bank address width `BANK_LG` must lie between 1 and 24 − log2(`NBANK`), which keeps all banks inside the first 16 MB of the SRAM window.

Top module: `amap_decoder`

## Requirements
- R1: While `rst` is high, at the next rising edge `sel`, `offset` and `err` all become zero.
- R2: A cycle with `valid` low gives `sel` = 0, `err` = 0 and `offset` = 0 one clock later, whatever the address.
- R3: Every result appears exactly one clock after its address. A cycle with `valid` high gives, one clock later, either exactly one `sel` bit set or `err` set, and never both.
- R4: The 4 KB peripheral slots and their `sel` bits are: 1 at 0x40000000, 2 at 0x40001000, 3 at 0x40002000, 4 at 0x40020000, 5 at 0x4002F000, 6 at 0x40080000, and 7 at 0x40081000. For each slot, `offset` equals the address minus the slot base.
- R5: SRAM bank i (0 ≤ i < NBANK) covers 2^BANK_LG bytes from 0x20000000 + i·2^BANK_LG. It drives `sel` bit 12+i, and `offset` is the address minus the bank base.
- R6: The 4 KB protection-register block of bank i sits at 0x50083000 + i·0x1000. It drives `sel` bit 12+NBANK+i.
- R7: Addresses 0x00000000–0x0FFFFFFF drive `sel` bit 0, and `offset` equals the address.
- R8: An address in window 0x1, 0x3 or 0x5 that hits no direct region is decoded as the same address with bit 28 cleared. The `sel` and `offset` it produces are those of that lower address.
- R9: Four secure-only slots inside window 0x5 win over the reflection. They are: 8 at 0x50080000, 9 at 0x50021000, 10 at 0x5002E000, and 11 at 0x50081000. For each, `offset` is relative to the slot base.
- R10: A valid address that resolves to no target raises `err` one clock later, with `sel` = 0 and `offset` = 0. Examples are gaps in window 0x4, space past the last bank, windows 0x6–0xF, and reflections of such gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Address strobe |
| addr | input | 32 | Byte address to decode |
| sel | output | 12+2·NBANK | One-hot target select, registered |
| offset | output | 32 | Address relative to the selected target base, registered |
| err | output | 1 | Decode error, registered |

## Verification
The bench builds the decoder with four banks and a 12-bit bank width. This shrinks each bank to 4 KB, so the edge between the last bank and the unmapped rest of the SRAM window lies where random offsets reach it. That same edge also shows up through the 0x3 reflection. Four banks put protection-register blocks at 0x50083000–0x50086000, so the empty slot just past them is reachable as well. That slot falls through the reflection into an empty peripheral slot and must raise an error.

// File: rtl/amap_pkg.sv
package amap_pkg;

    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned FIXED_TGTS = 12;
    localparam int unsigned SLOT_LG    = 12;
    localparam int unsigned WINDOW_LG  = 28;

    typedef enum int unsigned {
        TGT_CODE      = 0,
        TGT_TMR_A     = 1,
        TGT_TMR_B     = 2,
        TGT_TMR_DUAL  = 3,
        TGT_SYSID     = 4,
        TGT_SLOW_TMR  = 5,
        TGT_GUARD_NS  = 6,
        TGT_WDOG_NS   = 7,
        TGT_GUARD_S   = 8,
        TGT_SYSCTRL   = 9,
        TGT_SLOW_WDOG = 10,
        TGT_WDOG_S    = 11
    } fixed_tgt_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [5:0]        size_lg;
    } region_t;

    typedef struct packed {
        logic              in_mirror;
        logic [ADDR_W-1:0] addr;
    } fold_t;

    function automatic region_t region_of(input int unsigned idx,
                                          input int unsigned nbank,
                                          input int unsigned bank_lg);
        region_t r;
        r.size_lg = 6'(SLOT_LG);
        r.base    = '0;
        if (idx < FIXED_TGTS) begin
            case (idx)
                TGT_CODE: begin
                    r.base    = 32'h0000_0000;
                    r.size_lg = 6'(WINDOW_LG);
                end
                TGT_TMR_A:     r.base = 32'h4000_0000;
                TGT_TMR_B:     r.base = 32'h4000_1000;
                TGT_TMR_DUAL:  r.base = 32'h4000_2000;
                TGT_SYSID:     r.base = 32'h4002_0000;
                TGT_SLOW_TMR:  r.base = 32'h4002_F000;
                TGT_GUARD_NS:  r.base = 32'h4008_0000;
                TGT_WDOG_NS:   r.base = 32'h4008_1000;
                TGT_GUARD_S:   r.base = 32'h5008_0000;
                TGT_SYSCTRL:   r.base = 32'h5002_1000;
                TGT_SLOW_WDOG: r.base = 32'h5002_E000;
                default:       r.base = 32'h5008_1000;
            endcase
        end else if (idx < FIXED_TGTS + nbank) begin
            r.base    = 32'h2000_0000 + (32'(idx - FIXED_TGTS) << bank_lg);
            r.size_lg = 6'(bank_lg);
        end else begin
            r.base = 32'h5008_3000 + (32'(idx - FIXED_TGTS - nbank) << SLOT_LG);
        end
        return r;
    endfunction

    function automatic logic region_hit(input logic [ADDR_W-1:0] a,
                                        input region_t r);
        return (a >> r.size_lg) == (r.base >> r.size_lg);
    endfunction

    function automatic logic [ADDR_W-1:0] size_mask(input logic [5:0] lg);
        return (32'h1 << lg) - 32'h1;
    endfunction

    function automatic logic is_mirror_window(input logic [3:0] win);
        return (win == 4'h1) || (win == 4'h3) || (win == 4'h5);
    endfunction

endpackage

// File: rtl/amap_fold.sv
module amap_fold
    import amap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output fold_t             folded
);
    always_comb begin
        folded.in_mirror = is_mirror_window(addr[31:28]);
        folded.addr      = {addr[31:29], 1'b0, addr[27:0]};
    end
endmodule

// File: rtl/amap_match.sv
module amap_match
    import amap_pkg::*;
#(
    parameter int unsigned NBANK   = 4,
    parameter int unsigned BANK_LG = 15,
    parameter int unsigned NT      = FIXED_TGTS + 2 * NBANK
)(
    input  logic [ADDR_W-1:0] addr,
    output logic [NT-1:0]     hit
);
    for (genvar g = 0; g < NT; g++) begin : g_cmp
        localparam region_t REG = region_of(g, NBANK, BANK_LG);
        assign hit[g] = region_hit(addr, REG);
    end
endmodule

// File: rtl/amap_resolve.sv
module amap_resolve
    import amap_pkg::*;
#(
    parameter int unsigned NBANK   = 4,
    parameter int unsigned BANK_LG = 15,
    parameter int unsigned NT      = FIXED_TGTS + 2 * NBANK
)(
    input  logic [NT-1:0]     raw_hit,
    input  logic [NT-1:0]     fold_hit,
    input  logic [ADDR_W-1:0] raw_addr,
    input  fold_t             folded,
    output logic [NT-1:0]     sel,
    output logic [ADDR_W-1:0] offset,
    output logic              miss
);
    logic              use_raw;
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] masked [NT];

    always_comb begin
        use_raw  = |raw_hit;
        eff_addr = use_raw ? raw_addr : folded.addr;
        if (use_raw)
            sel = raw_hit;
        else if (folded.in_mirror)
            sel = fold_hit;
        else
            sel = '0;
        miss = ~|sel;
    end

    for (genvar g = 0; g < NT; g++) begin : g_off
        localparam region_t REG = region_of(g, NBANK, BANK_LG);
        localparam logic [ADDR_W-1:0] MASK = size_mask(REG.size_lg);
        assign masked[g] = sel[g] ? (eff_addr & MASK) : '0;
    end

    always_comb begin
        offset = '0;
        for (int k = 0; k < NT; k++)
            offset = offset | masked[k];
    end
endmodule

// File: rtl/amap_decoder.sv
module amap_decoder
    import amap_pkg::*;
#(
    parameter  int unsigned NBANK   = 4,
    parameter  int unsigned BANK_LG = 15,
    localparam int unsigned NT      = FIXED_TGTS + 2 * NBANK
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [31:0]       addr,
    output logic [NT-1:0]     sel,
    output logic [31:0]       offset,
    output logic              err
);
    fold_t             folded;
    logic [NT-1:0]     raw_hit;
    logic [NT-1:0]     fold_hit;
    logic [NT-1:0]     sel_d;
    logic [ADDR_W-1:0] off_d;
    logic              miss_d;

    amap_fold u_fold (
        .addr   (addr),
        .folded (folded)
    );

    amap_match #(.NBANK(NBANK), .BANK_LG(BANK_LG), .NT(NT)) u_raw (
        .addr (addr),
        .hit  (raw_hit)
    );

    amap_match #(.NBANK(NBANK), .BANK_LG(BANK_LG), .NT(NT)) u_mirror (
        .addr (folded.addr),
        .hit  (fold_hit)
    );

    amap_resolve #(.NBANK(NBANK), .BANK_LG(BANK_LG), .NT(NT)) u_resolve (
        .raw_hit  (raw_hit),
        .fold_hit (fold_hit),
        .raw_addr (addr),
        .folded   (folded),
        .sel      (sel_d),
        .offset   (off_d),
        .miss     (miss_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel    <= '0;
            offset <= '0;
            err    <= 1'b0;
        end else if (valid) begin
            sel    <= sel_d;
            offset <= off_d;
            err    <= miss_d;
        end else begin
            sel    <= '0;
            offset <= '0;
            err    <= 1'b0;
        end
    end
endmodule

// File: rtl/amap_decoder_chk.sv
module amap_decoder_chk #(
    parameter int unsigned NBANK   = 4,
    parameter int unsigned BANK_LG = 15,
    parameter int unsigned NT      = 12 + 2 * NBANK
)(
    input logic          clk,
    input logic          rst,
    input logic          valid,
    input logic [31:0]   addr,
    input logic [NT-1:0] sel,
    input logic [31:0]   offset,
    input logic          err
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (sel == '0 && offset == '0 && !err));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid |=> (sel == '0 && offset == '0 && !err));

    a_r3_single_outcome: assert property (@(posedge clk) disable iff (rst)
        valid |=> (($countones(sel) + 32'(err)) == 1));

    a_r3_sel_onehot0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    a_r7_code_window: assert property (@(posedge clk) disable iff (rst)
        (valid && addr[31:28] == 4'h0) |=> (sel[0] && offset == $past(addr)));

    a_r8_code_reflect: assert property (@(posedge clk) disable iff (rst)
        (valid && addr[31:28] == 4'h1)
            |=> (sel[0] && offset == {4'h0, $past(addr[27:0])}));

    a_r10_high_unmapped: assert property (@(posedge clk) disable iff (rst)
        (valid && addr[31:28] >= 4'h6) |=> err);

    a_r10_err_clean: assert property (@(posedge clk) disable iff (rst)
        err |-> (sel == '0 && offset == '0));
endmodule

bind amap_decoder amap_decoder_chk #(.NBANK(NBANK), .BANK_LG(BANK_LG), .NT(NT)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .valid  (valid),
    .addr   (addr),
    .sel    (sel),
    .offset (offset),
    .err    (err)
);

// File: tb/amap_decoder_test.sv
module amap_decoder_test;
    localparam int unsigned NB = 4;
    localparam int unsigned BL = 12;
    localparam int unsigned NT = 12 + 2 * NB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid = 1'b0;
    logic [31:0]   addr = '0;
    logic [NT-1:0] sel;
    logic [31:0]   offset;
    logic          err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    amap_decoder #(.NBANK(NB), .BANK_LG(BL)) uut (
        .clk(clk), .rst(rst), .valid(valid), .addr(addr),
        .sel(sel), .offset(offset), .err(err)
    );

    function automatic logic [31:0] t_base(input int k);
        logic [31:0] b [12] = '{32'h0000_0000, 32'h4000_0000, 32'h4000_1000,
                                32'h4000_2000, 32'h4002_0000, 32'h4002_F000,
                                32'h4008_0000, 32'h4008_1000, 32'h5008_0000,
                                32'h5002_1000, 32'h5002_E000, 32'h5008_1000};
        if (k < 12) return b[k];
        if (k < 12 + NB) return 32'h2000_0000 + 32'((k - 12) * (1 << BL));
        return 32'h5008_3000 + 32'((k - 12 - NB) * 4096);
    endfunction

    function automatic logic [32:0] t_size(input int k);
        if (k == 0) return 33'h1000_0000;
        if (k >= 12 && k < 12 + NB) return 33'(1 << BL);
        return 33'h1000;
    endfunction

    function automatic int lookup(input logic [31:0] a, output logic [31:0] off);
        off = '0;
        for (int k = 0; k < NT; k++) begin
            if ({1'b0, a} >= {1'b0, t_base(k)} &&
                {1'b0, a} < {1'b0, t_base(k)} + t_size(k)) begin
                off = a - t_base(k);
                return k;
            end
        end
        return -1;
    endfunction

    function automatic int model(input logic [31:0] a, output logic [31:0] off);
        int k;
        k = lookup(a, off);
        if (k < 0 && (a[31:28] == 4'h1 || a[31:28] == 4'h3 || a[31:28] == 4'h5))
            k = lookup(a - 32'h1000_0000, off);
        if (k < 0) off = '0;
        return k;
    endfunction

    task automatic apply(input logic [31:0] a, input logic v, input string req);
        logic [NT-1:0] e_sel;
        logic [31:0]   e_off;
        logic          e_err;
        int            k;
        @(negedge clk);
        addr  = a;
        valid = v;
        k = model(a, e_off);
        e_sel = (v && k >= 0) ? (NT'(1) << k) : '0;
        e_err = v && (k < 0);
        if (!(v && k >= 0)) e_off = '0;
        @(negedge clk);
        checks++;
        if (sel !== e_sel || offset !== e_off || err !== e_err) begin
            fails++;
            $display("FAIL %s addr=%h sel=%h exp %h err=%b exp %b off=%h exp %h",
                     req, a, sel, e_sel, err, e_err, offset, e_off);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'h5eed_c0de;
        void'($urandom(seed));
        valid = 1'b1;
        addr  = 32'h4000_0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (sel !== '0 || offset !== '0 || err !== 1'b0) begin
            fails++;
            $display("FAIL R1 sel=%h exp 0 err=%b exp 0 off=%h exp 0", sel, err, offset);
        end
        rst = 1'b0;

        apply(32'h4000_1000, 1'b0, "R2");
        apply(32'h7777_0000, 1'b0, "R2");
        apply(32'h4000_0abc, 1'b1, "R4");
        apply(32'h4000_1ffc, 1'b1, "R4");
        apply(32'h4000_2010, 1'b1, "R4");
        apply(32'h4002_0004, 1'b1, "R4");
        apply(32'h4002_F800, 1'b1, "R4");
        apply(32'h4008_0010, 1'b1, "R4");
        apply(32'h4008_1040, 1'b1, "R4");
        apply(32'h2000_0000, 1'b1, "R5");
        apply(32'h2000_1004, 1'b1, "R5");
        apply(32'h2000_3ffc, 1'b1, "R5");
        apply(32'h5008_3000, 1'b1, "R6");
        apply(32'h5008_6ff0, 1'b1, "R6");
        apply(32'h0000_0000, 1'b1, "R7");
        apply(32'h0FFF_FFFF, 1'b1, "R7");
        apply(32'h1ABC_DEF0, 1'b1, "R8");
        apply(32'h3000_3ffc, 1'b1, "R8");
        apply(32'h5000_1004, 1'b1, "R8");
        apply(32'h5002_0004, 1'b1, "R8");
        apply(32'h5008_0010, 1'b1, "R9");
        apply(32'h5002_1000, 1'b1, "R9");
        apply(32'h5002_E008, 1'b1, "R9");
        apply(32'h5008_1ffc, 1'b1, "R9");
        apply(32'h2000_4000, 1'b1, "R10");
        apply(32'h3000_4000, 1'b1, "R10");
        apply(32'h4000_3000, 1'b1, "R10");
        apply(32'h4002_E000, 1'b1, "R10");
        apply(32'h5008_7000, 1'b1, "R10");
        apply(32'h6000_0000, 1'b1, "R10");
        apply(32'hFFFF_FFFF, 1'b1, "R10");
        apply(32'h4000_0000, 1'b1, "R3");
        apply(32'h4000_0000, 1'b0, "R3");

        for (int n = 0; n < 3000; n++) begin
            int unsigned pick;
            int          k;
            logic [31:0] a;
            logic        v;
            pick = $urandom_range(0, 3);
            k    = int'($urandom_range(0, NT - 1));
            a    = t_base(k) + ($urandom & 32'(t_size(k) - 33'd1));
            if (pick == 1 && (a[31:28] == 4'h0 || a[31:28] == 4'h2 || a[31:28] == 4'h4))
                a = a + 32'h1000_0000;
            else if (pick == 2)
                a = a + 32'(t_size(k));
            else if (pick == 3)
                a = $urandom;
            v = ($urandom_range(0, 9) != 0);
            apply(a, v, "R3");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule